// File: doc/BRIEF.md
# Decimal-Mode Adder with Corrected Flags

This block is the combinational add/subtract unit of a small 8-bit processor. It takes two operands, a carry-in, a subtract select and a decimal-mode enable. It returns a result, a carry-out and three status flags: signed overflow, negative and zero. Subtraction is done as the first operand plus the one's complement of the second plus carry-in. A carry-out of 1 therefore means that no borrow occurred.

In decimal mode the operands are read as packed BCD, two digits per byte. The unit forms a per-digit sum in which the carry between digits follows decimal rules for addition. It then adds a correction to each 4-bit digit on its own. No carry passes from one digit's correction into the next digit.

A build-time parameter sets where the negative and zero flags come from. They are taken either from the corrected result or from the uncorrected intermediate sum. Storing the flags, decoding instructions and sequencing over several cycles are left to the surrounding core.

Top module: `decimal_adder`

## Requirements
- R1: With `dec_en` low, the unit adds `opa + opb + cin` when `sub_en` is low, or `opa + ~opb + cin` when `sub_en` is high. `result` is the low 8 bits of that sum, `cout` is bit 8, and no correction is applied.
- R2: In binary subtraction with `cin` = 1, `cout` is 1 exactly when `opa >= opb` as unsigned numbers, so 1 means no borrow.
- R3: `ovf` is 1 when both of these hold: the top bit of `opa` equals the top bit of the effective second operand (`opb`, or `~opb` when subtracting), and bit 7 of the intermediate sum differs from the top bit of `opa`. This holds in both modes.
- R4: In decimal addition with valid BCD operands (each nibble 0 to 9), `result` is the BCD encoding of `(A + B + cin) mod 100` and `cout` is 1 when that total is 100 or more.
- R5: In decimal subtraction with valid BCD operands, `result` is the BCD encoding of `(A - B - (1 - cin)) mod 100` and `cout` is 1 when that difference is not negative.
- R6: With `CORRECT_FLAGS` = 1, `neg` equals `result[7]` and `zero` is 1 only when all 8 bits of `result` are 0.
- R7: With `CORRECT_FLAGS` = 0, `neg` and `zero` come from the intermediate sum, also in decimal mode. That sum is defined as follows. Low nibble: `lo = opa[3:0] + b'[3:0] + cin` (5 bits). High nibble: `opa[7:4] + b'[7:4] + k`, where `b'` is the effective second operand. In decimal addition, `k = (lo > 9)`; otherwise `k = lo[4]`.
- R8: In decimal mode each result nibble is the matching intermediate-sum nibble plus a correction, modulo 16, with no carry between nibbles. For addition the correction is 6 when that digit's decimal carry (`lo > 9` for the low digit; high 5-bit sum `> 9` for the high digit) is set, else 0. For subtraction it is 10 when the digit's binary carry-out is clear, else 0. `cout` is the high digit's carry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | 8 | First operand |
| opb | input | 8 | Second operand |
| cin | input | 1 | Carry-in (1 = no borrow when subtracting) |
| sub_en | input | 1 | 1 selects subtraction |
| dec_en | input | 1 | 1 selects packed-BCD arithmetic |
| result | output | 8 | Digit-corrected result |
| cout | output | 1 | Carry-out |
| ovf | output | 1 | Signed overflow of the intermediate sum |
| neg | output | 1 | Negative flag |
| zero | output | 1 | Zero flag |

## Verification
The bench builds the unit twice with the default two digits: once with `CORRECT_FLAGS` = 1 and once with `CORRECT_FLAGS` = 0. Both copies receive the same inputs. Running them side by side shows where the two flag bases differ, for example a decimal sum that wraps to 00 while its intermediate sum has bit 7 set. Every operand pair, carry-in and operation is swept in both modes. Non-BCD operands in decimal mode exercise the independent nibble correction, and valid BCD pairs are also compared against plain decimal arithmetic.

// File: rtl/bcd_adder_pkg.sv
package bcd_adder_pkg;

  localparam int NIB_W = 4;
  localparam logic [3:0] DIGIT_MAX = 4'd9;
  localparam logic [3:0] FIX_ADD   = 4'd6;
  localparam logic [3:0] FIX_SUB   = 4'd10;

  // 5-bit sum of two nibbles and a carry
  function automatic logic [4:0] nib_sum(input logic [3:0] x, input logic [3:0] y,
                                         input logic c);
    return {1'b0, x} + {1'b0, y} + {4'b0000, c};
  endfunction

  // carry out of one digit: decimal rule for BCD add, binary otherwise
  function automatic logic digit_carry(input logic [4:0] s, input logic dec_add);
    return dec_add ? (s > {1'b0, DIGIT_MAX}) : s[4];
  endfunction

  // correction added to one digit of the intermediate sum
  function automatic logic [3:0] digit_fix(input logic dec, input logic sub,
                                           input logic carry);
    logic [3:0] f;
    if (!dec)     f = 4'd0;
    else if (sub) f = carry ? 4'd0 : FIX_SUB;
    else          f = carry ? FIX_ADD : 4'd0;
    return f;
  endfunction

  // two's-complement overflow from the sign bits
  function automatic logic signed_ovf(input logic a_top, input logic b_top,
                                      input logic s_top);
    return (a_top == b_top) && (s_top != a_top);
  endfunction

endpackage

// File: rtl/bcd_sum_stage.sv
module bcd_sum_stage
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = NIB_W * DIGITS
) (
  input  logic [W-1:0]      opa,
  input  logic [W-1:0]      opb,
  input  logic              cin,
  input  logic              sub_en,
  input  logic              dec_en,
  output logic [W-1:0]      sum,
  output logic [DIGITS-1:0] dig_carry,
  output logic              b_top
);

  logic [W-1:0]    b_eff;
  logic [DIGITS:0] chain;
  logic            dec_add;

  assign b_eff    = sub_en ? ~opb : opb;
  assign dec_add  = dec_en & ~sub_en;
  assign chain[0] = cin;
  assign b_top    = b_eff[W-1];

  for (genvar i = 0; i < DIGITS; i++) begin : g_digit
    logic [4:0] ns;
    assign ns = nib_sum(opa[i*NIB_W +: NIB_W], b_eff[i*NIB_W +: NIB_W], chain[i]);
    assign sum[i*NIB_W +: NIB_W] = ns[3:0];
    assign chain[i+1]            = digit_carry(ns, dec_add);
    assign dig_carry[i]          = chain[i+1];
  end

endmodule

// File: rtl/bcd_fix_stage.sv
module bcd_fix_stage
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 2,
  localparam int W = NIB_W * DIGITS
) (
  input  logic [W-1:0]      sum,
  input  logic [DIGITS-1:0] dig_carry,
  input  logic              sub_en,
  input  logic              dec_en,
  output logic [W-1:0]      adj,
  output logic [W-1:0]      result,
  output logic              cout
);

  for (genvar i = 0; i < DIGITS; i++) begin : g_fix
    assign adj[i*NIB_W +: NIB_W]    = digit_fix(dec_en, sub_en, dig_carry[i]);
    // each digit wraps on its own; nothing carries into the next digit
    assign result[i*NIB_W +: NIB_W] = sum[i*NIB_W +: NIB_W] + adj[i*NIB_W +: NIB_W];
  end

  assign cout = dig_carry[DIGITS-1];

endmodule

// File: rtl/bcd_flag_gen.sv
module bcd_flag_gen
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter bit CORRECT_FLAGS = 1'b1,
  localparam int W = NIB_W * DIGITS
) (
  input  logic [W-1:0] sum,
  input  logic [W-1:0] result,
  input  logic         a_top,
  input  logic         b_top,
  output logic         ovf,
  output logic         neg,
  output logic         zero
);

  logic [W-1:0] basis;

  if (CORRECT_FLAGS) begin : g_corrected
    assign basis = result;
  end else begin : g_raw
    assign basis = sum;
  end

  assign ovf  = signed_ovf(a_top, b_top, sum[W-1]);
  assign neg  = basis[W-1];
  assign zero = ~|basis;

endmodule

// File: rtl/decimal_adder.sv
module decimal_adder
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter bit CORRECT_FLAGS = 1'b1,
  localparam int W = NIB_W * DIGITS
) (
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  input  logic         cin,
  input  logic         sub_en,
  input  logic         dec_en,
  output logic [W-1:0] result,
  output logic         cout,
  output logic         ovf,
  output logic         neg,
  output logic         zero
);

  logic [W-1:0]      sum_w;
  logic [DIGITS-1:0] dig_carry_w;
  logic [W-1:0]      adj_w;
  logic              b_top_w;

  bcd_sum_stage #(.DIGITS(DIGITS)) u_sum (
    .opa(opa), .opb(opb), .cin(cin), .sub_en(sub_en), .dec_en(dec_en),
    .sum(sum_w), .dig_carry(dig_carry_w), .b_top(b_top_w)
  );

  bcd_fix_stage #(.DIGITS(DIGITS)) u_fix (
    .sum(sum_w), .dig_carry(dig_carry_w), .sub_en(sub_en), .dec_en(dec_en),
    .adj(adj_w), .result(result), .cout(cout)
  );

  bcd_flag_gen #(.DIGITS(DIGITS), .CORRECT_FLAGS(CORRECT_FLAGS)) u_flag (
    .sum(sum_w), .result(result), .a_top(opa[W-1]), .b_top(b_top_w),
    .ovf(ovf), .neg(neg), .zero(zero)
  );

endmodule

// File: rtl/decimal_adder_chk.sv
module decimal_adder_chk
  import bcd_adder_pkg::*;
#(
  parameter int DIGITS = 2,
  parameter bit CORRECT_FLAGS = 1'b1,
  localparam int W = NIB_W * DIGITS
) (
  input logic [W-1:0]      opa,
  input logic [W-1:0]      opb,
  input logic              cin,
  input logic              sub_en,
  input logic              dec_en,
  input logic [W-1:0]      result,
  input logic              cout,
  input logic              ovf,
  input logic              neg,
  input logic              zero,
  input logic [W-1:0]      sum_w,
  input logic [W-1:0]      adj_w
);

  function automatic logic all_bcd(input logic [W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < DIGITS; i++)
      if (v[i*NIB_W +: NIB_W] > DIGIT_MAX) ok = 1'b0;
    return ok;
  endfunction

  always_comb begin
    // R1: binary mode leaves the intermediate sum untouched
    if (!dec_en)
      a_r1_bin_passthrough: assert (result == sum_w && adj_w == '0)
        else $error("a_r1_bin_passthrough");
    // R2: binary subtract carry is the no-borrow indication
    if (!dec_en && sub_en && cin)
      a_r2_no_borrow: assert (cout == (opa >= opb))
        else $error("a_r2_no_borrow");
    // R3: overflow only when operand signs agree
    if (ovf)
      a_r3_sign_agree: assert (opa[W-1] == (sub_en ? ~opb[W-1] : opb[W-1]))
        else $error("a_r3_sign_agree");
    // R4 / R5: valid BCD in gives valid BCD out
    if (dec_en && all_bcd(opa) && all_bcd(opb))
      a_r4_r5_bcd_out: assert (all_bcd(result))
        else $error("a_r4_r5_bcd_out");
    // R8: correction values per digit
    for (int i = 0; i < DIGITS; i++) begin
      if (dec_en && !sub_en)
        a_r8_add_fix: assert (adj_w[i*NIB_W +: NIB_W] inside {4'd0, FIX_ADD})
          else $error("a_r8_add_fix");
      if (dec_en && sub_en)
        a_r8_sub_fix: assert (adj_w[i*NIB_W +: NIB_W] inside {4'd0, FIX_SUB})
          else $error("a_r8_sub_fix");
    end
  end

  if (CORRECT_FLAGS) begin : g_chk_corr
    always_comb begin
      a_r6_flags_on_result: assert (neg == result[W-1] && zero == (result == '0))
        else $error("a_r6_flags_on_result");
    end
  end else begin : g_chk_raw
    always_comb begin
      a_r7_flags_on_sum: assert (neg == sum_w[W-1] && zero == (sum_w == '0))
        else $error("a_r7_flags_on_sum");
    end
  end

endmodule

bind decimal_adder decimal_adder_chk #(.DIGITS(DIGITS), .CORRECT_FLAGS(CORRECT_FLAGS)) u_chk (
  .opa(opa), .opb(opb), .cin(cin), .sub_en(sub_en), .dec_en(dec_en),
  .result(result), .cout(cout), .ovf(ovf), .neg(neg), .zero(zero),
  .sum_w(sum_w), .adj_w(adj_w)
);

// File: tb/tb_decimal_adder.sv
`timescale 1ns/1ps
module tb_decimal_adder;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic       ci = 1'b0, sub = 1'b0, dec = 1'b0;
  logic [7:0] res_c, res_r;
  logic       co_c, v_c, n_c, z_c, co_r, v_r, n_r, z_r;
  int         n_tests = 0, n_fail = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  decimal_adder #(.CORRECT_FLAGS(1'b1)) dut (
    .opa(a), .opb(b), .cin(ci), .sub_en(sub), .dec_en(dec),
    .result(res_c), .cout(co_c), .ovf(v_c), .neg(n_c), .zero(z_c)
  );

  decimal_adder #(.CORRECT_FLAGS(1'b0)) dut_raw (
    .opa(a), .opb(b), .cin(ci), .sub_en(sub), .dec_en(dec),
    .result(res_r), .cout(co_r), .ovf(v_r), .neg(n_r), .zero(z_r)
  );

  // {res, cout, v, n, z} from the requirements, written as integer arithmetic
  function automatic logic [11:0] ref_out(input int ia, input int ib, input int ic,
                                          input int isub, input int idec, input int corr);
    int bl, bh, lo, lc, hi, hc, raw, fl, fh, r, bt, v, basis;
    bl = isub ? 15 - ib % 16 : ib % 16;
    bh = isub ? 15 - ib / 16 : ib / 16;
    lo = ia % 16 + bl + ic;
    lc = (idec != 0 && isub == 0) ? int'(lo > 9) : int'(lo > 15);
    hi = ia / 16 + bh + lc;
    hc = (idec != 0 && isub == 0) ? int'(hi > 9) : int'(hi > 15);
    raw = (hi % 16) * 16 + lo % 16;
    fl = 0; fh = 0;
    if (idec != 0) begin
      if (isub != 0) begin fl = lc ? 0 : 10; fh = hc ? 0 : 10; end
      else           begin fl = lc ? 6 : 0;  fh = hc ? 6 : 0;  end
    end
    r  = ((hi + fh) % 16) * 16 + (lo + fl) % 16;
    bt = isub ? 1 - ib / 128 : ib / 128;
    v  = int'((ia / 128 == bt) && (raw / 128 != ia / 128));
    basis = corr ? r : raw;
    return {r[7:0], hc[0], v[0], basis >= 128, basis == 0};
  endfunction

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s a=%h b=%h ci=%0d sub=%0d dec=%0d actual=%h expected=%h",
               req, a, b, ci, sub, dec, act, exp);
    end
  endtask

  // {dec, sub, ci, a, b, res, cout, v, n_corr, z_corr, n_raw, z_raw}
  localparam logic [32:0] VEC [0:12] = '{
    {3'b000, 8'h7F, 8'h01, 8'h80, 6'b011010},  // R1 R3 signed overflow
    {3'b000, 8'hFF, 8'h01, 8'h00, 6'b100101},  // R1 wrap
    {3'b011, 8'h50, 8'h70, 8'hE0, 6'b001010},  // R2 borrow
    {3'b011, 8'h80, 8'h01, 8'h7F, 6'b110000},  // R2 R3 sub overflow
    {3'b100, 8'h99, 8'h01, 8'h00, 6'b100110},  // R4 R6 R7 flag bases differ
    {3'b100, 8'h58, 8'h46, 8'h04, 6'b110010},  // R4 R3
    {3'b101, 8'h12, 8'h34, 8'h47, 6'b000000},  // R4 carry-in
    {3'b111, 8'h00, 8'h01, 8'h99, 6'b001010},  // R5 wrap below zero
    {3'b111, 8'h46, 8'h12, 8'h34, 6'b100000},  // R5
    {3'b111, 8'h40, 8'h40, 8'h00, 6'b100101},  // R5 R6 zero
    {3'b100, 8'h00, 8'h00, 8'h00, 6'b000101},  // R4 zero
    {3'b100, 8'h50, 8'h50, 8'h00, 6'b110110},  // R4 R6 R7
    {3'b100, 8'h0F, 8'h01, 8'h16, 6'b000000}   // R8 non-BCD digit, no cross carry
  };

  initial begin
    #780000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    // reset state: zero inputs held in reset
    #1;
    check("R1 reset", {res_c, co_c, v_c, n_c, z_c}, 12'h001);
    check("R7 reset", {res_r, co_r, v_r, n_r, z_r}, 12'h001);
    #8 rst_n = 1'b1;
    #0.5;

    foreach (VEC[i]) begin
      logic [32:0] e;
      e = VEC[i];
      {dec, sub, ci, a, b} = e[32:14];
      #0.5;
      check("R6 vector", {res_c, co_c, v_c, n_c, z_c}, {e[13:4], e[3:2]});
      check("R7 vector", {res_r, co_r, v_r, n_r, z_r}, {e[13:4], e[1:0]});
      #0.5;
    end

    // exhaustive sweep: binary (R1 R2 R3) and decimal (R4 R5 R8), both flag bases
    for (int m = 0; m < 2; m++) begin
      for (int op = 0; op < 4; op++) begin
        for (int x = 0; x < 256; x++) begin
          for (int y = 0; y < 256; y++) begin
            dec = m[0]; sub = op[1]; ci = op[0];
            a = x[7:0]; b = y[7:0];
            #0.5;
            check(m ? "R8 sweep corr" : "R1 sweep corr", {res_c, co_c, v_c, n_c, z_c},
                  ref_out(x, y, op % 2, op / 2, m, 1));
            check(m ? "R7 sweep raw" : "R3 sweep raw", {res_r, co_r, v_r, n_r, z_r},
                  ref_out(x, y, op % 2, op / 2, m, 0));
            if (m == 1 && x % 16 < 10 && x / 16 < 10 && y % 16 < 10 && y / 16 < 10) begin
              int da, db, s, exp_s;
              logic exp_c;
              da = (x / 16) * 10 + x % 16;
              db = (y / 16) * 10 + y % 16;
              if (op / 2 == 0) begin
                s = da + db + op % 2; exp_c = s >= 100; exp_s = s % 100;
              end else begin
                s = da - db - (1 - op % 2); exp_c = s >= 0; exp_s = (s + 100) % 100;
              end
              check(op / 2 == 0 ? "R4 decimal add" : "R5 decimal sub",
                    {3'b000, res_c, co_c},
                    {3'b000, 4'((exp_s / 10)), 4'((exp_s % 10)), exp_c});
            end
            #0.5;
          end
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule